// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Scaler

This block holds an 8-bit timer/counter and a watchdog timer that share a single 8-bit scaler counter. One option bit decides where the scaler sits. It can sit in front of the timer as a prescaler, or behind the watchdog's base period as a postscaler. The scaler itself has no host access. It is cleared by the events that matter to whichever side it serves.

The timer counts instruction cycles, or edges of an external input pin. The active edge of the pin is selectable. The oscillator clock `clk` is split into four phases, and one instruction cycle spans all four. Counting events from the pin are resynchronised and applied only on phases 1 and 3. A host writes the count, the option register and the interrupt register through write strobes. A wrap of the count from 0xFF to 0x00 raises a sticky overflow flag. The flag, gated by its enable bit, drives an interrupt line. The watchdog raises a one-cycle reset pulse when it expires, unless it is cleared through `wdt_clr` in time.

Top module: `tmr_wdt_scaler`

## Requirements
- R1: After reset the option register reads 0xFF, so the scaler serves the watchdog at its largest ratio. The count reads 0x00, the interrupt register reads 0x00, and `tmr_irq` and `wdt_rst` are low.
- R2: Option bit 3 = 0 gives the timer a prescaler. Option bits 2:0 = n divide the timer source by 2^(n+1). With the internal source, the count then advances once every 2^(n+1) instruction cycles (4·2^(n+1) clocks).
- R3: Option bit 3 = 1 gives the timer no prescaler. With the internal source (option bit 5 = 0), the count advances once per instruction cycle (4 clocks).
- R4: Option bit 5 = 1 selects the external pin. Option bit 4 = 0 counts rising edges and 1 counts falling edges. Each pin level must last at least 2 clocks. Every qualifying edge advances the count by exactly one. The count changes only after a clock edge taken on phase 1 or 3.
- R5: A count write loads the value on the next cycle. If option bit 3 = 0, it also clears the scaler. The next two counting events after the write are dropped.
- R6: A wrap from 0xFF to 0x00 sets the flag in interrupt register bit 2. The flag stays set until the host writes it to 0. `tmr_irq` equals the flag ANDed with the enable in bit 5.
- R7: The watchdog base period is 2^WDT_BASE_W instruction cycles. With option bit 3 = 1, a timeout comes every 2^n base periods. Each timeout gives a `wdt_rst` pulse exactly one clock long.
- R8: `wdt_clr` restarts the base period. If option bit 3 = 1, it also clears the scaler. No timeout is reported on the cycle after a clear.
- R9: A write that changes option bit 3 clears the scaler. A switch of assignment therefore cannot cut a watchdog interval short.
- R10: With option bit 3 = 0, the watchdog times out at the end of every base period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| tmr_we | input | 1 | Count write strobe |
| tmr_wdata | input | 8 | Count write value |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option value: bit5 source, bit4 edge, bit3 assignment, bits2:0 ratio |
| irq_we | input | 1 | Interrupt register write strobe |
| irq_wdata | input | 8 | Interrupt value: bit5 enable, bit2 flag |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_count | output | 8 | Current count |
| opt_rdata | output | 8 | Option register |
| irq_rdata | output | 8 | Interrupt register, unused bits zero |
| tmr_irq | output | 1 | Overflow interrupt request |
| wdt_rst | output | 1 | Watchdog timeout pulse |

## Verification
Several properties are checked on every cycle. The count moves by at most one and only after a phase-1 or phase-3 edge. A write loads its value exactly, and the overflow flag stays set and follows every wrap. The reset pulse lasts a single cycle and never comes directly after a clear, and a pin edge pulse is never longer than one cycle. The other behaviours show up only in the bench's scenarios: the real division ratios, the dropped counts after a write, the edge selection, and the scaler being cleared when the assignment switches or the watchdog is cleared. The switch scenario leaves the scaler one tick short of a timeout and then shows that no early watchdog pulse follows.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int CNT_W   = 8;
    localparam int SCAL_W  = 8;
    localparam int SEL_W   = 3;
    localparam int PH_W    = 2;
    localparam int INH_W   = 2;
    localparam int OPT_SRC  = 5;
    localparam int OPT_EDGE = 4;
    localparam int OPT_PSA  = 3;
    localparam int IRQ_EN   = 5;
    localparam int IRQ_FLAG = 2;

    typedef struct packed {
        logic [SCAL_W-1:0] scal;
        logic [CNT_W-1:0]  cnt;
        logic [INH_W-1:0]  inh;
        logic              pend;
        logic              flag;
        logic              ie;
        logic [CNT_W-1:0]  opt;
        logic              wrst;
    } tws_state_t;
endpackage

// File: rtl/tws_phase.sv
module tws_phase #(
    parameter int PH_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic instr_tick,
    output logic sample_en
);
    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign instr_tick = &ph_q;
    assign sample_en  = ph_q[0];
endmodule

// File: rtl/tws_pin_sync.sv
module tws_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic prev_d, prev_q;
    logic lvl;

    assign lvl = sync_q[STAGES-1];

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin};
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign edge_pulse = fall_sel ? (~lvl & prev_q) : (lvl & ~prev_q);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse && $stable(fall_sel) |=> !edge_pulse); // R4
endmodule

// File: rtl/tws_wdt_base.sv
module tws_wdt_base #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_tick,
    input  logic clear,
    output logic tick
);
    logic [W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (clear)           base_d = '0;
        else if (instr_tick) base_d = base_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign tick = instr_tick & (&base_q) & ~clear;

    AST_TICK_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R7
endmodule

// File: rtl/tmr_wdt_scaler.sv
module tmr_wdt_scaler
    import tws_pkg::*;
#(
    parameter int WDT_BASE_W  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             tmr_we,
    input  logic [CNT_W-1:0] tmr_wdata,
    input  logic             opt_we,
    input  logic [CNT_W-1:0] opt_wdata,
    input  logic             irq_we,
    input  logic [CNT_W-1:0] irq_wdata,
    input  logic             wdt_clr,
    output logic [CNT_W-1:0] tmr_count,
    output logic [CNT_W-1:0] opt_rdata,
    output logic [CNT_W-1:0] irq_rdata,
    output logic             tmr_irq,
    output logic             wdt_rst
);
    localparam logic [SCAL_W:0] ONE_W = (SCAL_W+1)'(1);
    localparam logic [SCAL_W:0] TWO_W = (SCAL_W+1)'(2);

    tws_state_t st_d, st_q;
    logic instr_tick, sample_en, ext_edge, wdt_tick;
    logic psa, src_pulse, scaled, inc_raw, inc, to_hit, scal_clr;
    logic [SEL_W-1:0] ratio;
    logic [SCAL_W:0]  pre_mask, post_mask;

    tws_phase #(.PH_W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick), .sample_en(sample_en)
    );

    tws_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk_i),
        .fall_sel(st_q.opt[OPT_EDGE]), .edge_pulse(ext_edge)
    );

    tws_wdt_base #(.W(WDT_BASE_W)) u_base (
        .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick),
        .clear(wdt_clr), .tick(wdt_tick)
    );

    always_comb begin
        st_d      = st_q;
        psa       = st_q.opt[OPT_PSA];
        ratio     = st_q.opt[SEL_W-1:0];
        pre_mask  = (TWO_W << ratio) - ONE_W;
        post_mask = (ONE_W << ratio) - ONE_W;
        src_pulse = st_q.opt[OPT_SRC] ? ext_edge : instr_tick;

        // prescaler carry or straight through
        scaled = psa ? src_pulse
                     : src_pulse && ((st_q.scal & pre_mask[SCAL_W-1:0]) == pre_mask[SCAL_W-1:0]);
        // watchdog postscaler hit
        to_hit = wdt_tick && (!psa ||
                 ((st_q.scal & post_mask[SCAL_W-1:0]) == post_mask[SCAL_W-1:0]));

        // resynchronise counting events to phases 1 and 3
        inc_raw = st_q.pend | scaled;
        inc     = sample_en & inc_raw;
        st_d.pend = sample_en ? 1'b0 : inc_raw;

        scal_clr = (tmr_we && !psa) || (wdt_clr && psa) ||
                   (opt_we && (opt_wdata[OPT_PSA] != psa));
        if (scal_clr)                     st_d.scal = '0;
        else if (psa ? wdt_tick : src_pulse) st_d.scal = st_q.scal + 1'b1;

        if (tmr_we) begin
            st_d.cnt  = tmr_wdata;
            st_d.inh  = INH_W'(2);
            st_d.pend = 1'b0;
        end else if (inc) begin
            if (st_q.inh != '0) st_d.inh = st_q.inh - 1'b1;
            else                st_d.cnt = st_q.cnt + 1'b1;
        end

        if (irq_we) begin
            st_d.ie   = irq_wdata[IRQ_EN];
            st_d.flag = irq_wdata[IRQ_FLAG];
        end
        if (!tmr_we && inc && st_q.inh == '0 && (&st_q.cnt)) st_d.flag = 1'b1;

        if (opt_we) st_d.opt = opt_wdata;
        st_d.wrst = to_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.opt  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_count = st_q.cnt;
    assign opt_rdata = st_q.opt;
    assign irq_rdata = CNT_W'({st_q.ie, 2'b00, st_q.flag, 2'b00});
    assign tmr_irq   = st_q.flag & st_q.ie;
    assign wdt_rst   = st_q.wrst;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_we |=> (tmr_count == $past(tmr_count)) ||
                    (tmr_count == $past(tmr_count) + 1'b1)); // R2
    AST_SAMPLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_we && !sample_en |=> $stable(tmr_count)); // R4
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> tmr_count == $past(tmr_wdata)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag && !irq_we |=> st_q.flag); // R6
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_we && tmr_count == 8'hFF |=> (tmr_count == 8'h00) -> irq_rdata[IRQ_FLAG]); // R6
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst); // R7
    AST_CLR_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_rst); // R8
endmodule

// File: tb/sim_tmr_wdt_scaler.sv
module sim_tmr_wdt_scaler;
    localparam int BW     = 5;
    localparam int BASE_N = 1 << BW;
    localparam int PERIOD = 4 * BASE_N;

    logic clk = 0, rst_n = 0, ext_clk_i = 0;
    logic tmr_we = 0, opt_we = 0, irq_we = 0, wdt_clr = 0;
    logic [7:0] tmr_wdata = 0, opt_wdata = 0, irq_wdata = 0;
    logic [7:0] tmr_count, opt_rdata, irq_rdata;
    logic tmr_irq, wdt_rst;

    int tests = 0, fails = 0;
    bit done = 0;

    tmr_wdt_scaler #(.WDT_BASE_W(BW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .opt_we(opt_we), .opt_wdata(opt_wdata),
        .irq_we(irq_we), .irq_wdata(irq_wdata), .wdt_clr(wdt_clr),
        .tmr_count(tmr_count), .opt_rdata(opt_rdata), .irq_rdata(irq_rdata),
        .tmr_irq(tmr_irq), .wdt_rst(wdt_rst)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_ph, m_base, m_scal, m_cnt, m_inh, n;
    bit m_s1, m_s2, m_p, m_pend, m_flag, m_ie, m_wrst;
    bit [7:0] m_opt;
    bit psa, itick, samp, ep, src, wt, to, scl, iraw, incr, clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_base = 0; m_scal = 0; m_cnt = 0; m_inh = 0;
            m_s1 = 0; m_s2 = 0; m_p = 0; m_pend = 0; m_flag = 0; m_ie = 0;
            m_wrst = 0; m_opt = 8'hFF;
        end else begin
            itick = (m_ph == 3);
            samp  = (m_ph % 2) == 1;
            ep    = m_opt[4] ? (!m_s2 && m_p) : (m_s2 && !m_p);
            m_p = m_s2; m_s2 = m_s1; m_s1 = ext_clk_i;
            src   = m_opt[5] ? ep : itick;
            wt    = itick && (m_base == BASE_N - 1) && !wdt_clr;
            if (wdt_clr) m_base = 0;
            else if (itick) m_base = (m_base + 1) % BASE_N;
            n   = int'(m_opt[2:0]);
            psa = m_opt[3];
            to  = wt && (!psa || (m_scal % (1 << n)) == (1 << n) - 1);
            scl = psa ? src : (src && (m_scal % (2 << n)) == (2 << n) - 1);
            iraw = m_pend || scl;
            incr = samp && iraw;
            m_pend = samp ? 0 : iraw;
            clr = (tmr_we && !psa) || (wdt_clr && psa) || (opt_we && opt_wdata[3] != psa);
            if (clr) m_scal = 0;
            else if (psa ? wt || (itick && m_base == 0 && !wdt_clr && wt) : src) m_scal = (m_scal + 1) % 256;
            if (irq_we) begin m_ie = irq_wdata[5]; m_flag = irq_wdata[2]; end
            if (tmr_we) begin
                m_cnt = tmr_wdata; m_inh = 2; m_pend = 0;
            end else if (incr) begin
                if (m_inh > 0) m_inh--;
                else begin
                    if (m_cnt == 255) m_flag = 1;
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
            if (opt_we) m_opt = opt_wdata;
            m_wrst = to;
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(tmr_count) == m_cnt, "R2 count vs model", tmr_count, m_cnt);
            chk(irq_rdata == {2'b00, m_ie, 2'b00, m_flag, 2'b00}, "R6 irq reg vs model",
                irq_rdata, {2'b00, m_ie, 2'b00, m_flag, 2'b00});
            chk(tmr_irq == (m_flag && m_ie), "R6 irq line vs model", tmr_irq, m_flag && m_ie);
            chk(wdt_rst == m_wrst, "R7 wdt pulse vs model", wdt_rst, m_wrst);
            chk(opt_rdata == m_opt, "R1 option vs model", opt_rdata, m_opt);
        end
    end

    task automatic wr_opt(input logic [7:0] v);
        @(negedge clk); opt_we = 1; opt_wdata = v;
        @(negedge clk); opt_we = 0;
    endtask
    task automatic wr_tmr(input logic [7:0] v);
        @(negedge clk); tmr_we = 1; tmr_wdata = v;
        @(negedge clk); tmr_we = 0;
    endtask
    task automatic wr_irq(input logic [7:0] v);
        @(negedge clk); irq_we = 1; irq_wdata = v;
        @(negedge clk); irq_we = 0;
    endtask
    task automatic clr_wdt();
        @(negedge clk); wdt_clr = 1;
        @(negedge clk); wdt_clr = 0;
    endtask
    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask
    task automatic count_gap(output int gap);
        logic [7:0] s;
        s = tmr_count; gap = 0;
        while (tmr_count == s && gap < 5000) begin @(negedge clk); gap++; end
    endtask
    task automatic wdt_gap(output int gap);
        int g = 0;
        while (!wdt_rst && g < 20000) begin @(negedge clk); g++; end
        @(negedge clk); gap = 1;
        while (!wdt_rst && gap < 20000) begin @(negedge clk); gap++; end
    endtask
    task automatic pin_pulses(input int k, input int hi, input int lo);
        for (int i = 0; i < k; i++) begin
            ext_clk_i = 1; idle(hi);
            ext_clk_i = 0; idle(lo);
        end
    endtask
    task automatic pulses_in(input int k, output int cnt);
        cnt = 0;
        for (int i = 0; i < k; i++) begin @(negedge clk); if (wdt_rst) cnt++; end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int g, c0, np;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(opt_rdata == 8'hFF, "R1 option reset", opt_rdata, 8'hFF);
        chk(tmr_count == 8'h00, "R1 count reset", tmr_count, 0);
        chk(irq_rdata == 8'h00, "R1 irq reset", irq_rdata, 0);
        chk(!wdt_rst && !tmr_irq, "R1 outputs low", wdt_rst, 0);

        // R3 no prescale, internal source
        wr_opt(8'h08);
        count_gap(g); count_gap(g); chk(g == 4, "R3 interval", g, 4);
        count_gap(g); chk(g == 4, "R3 interval", g, 4);
        // R7 watchdog ratios
        wdt_gap(g); chk(g == PERIOD, "R7 wdt 1:1", g, PERIOD);
        wr_opt(8'h09);
        wdt_gap(g); wdt_gap(g); chk(g == 2 * PERIOD, "R7 wdt 1:2", g, 2 * PERIOD);

        // R2 prescaler ratios
        wr_opt(8'h00);
        count_gap(g); count_gap(g); chk(g == 8, "R2 1:2 interval", g, 8);
        wr_opt(8'h02);
        count_gap(g); count_gap(g); count_gap(g); chk(g == 32, "R2 1:8 interval", g, 32);
        // R10 watchdog without postscaler
        wdt_gap(g); chk(g == PERIOD, "R10 wdt base period", g, PERIOD);

        // R5 write inhibit
        wr_opt(8'h08);
        @(negedge clk); tmr_we = 1; tmr_wdata = 8'h10;
        @(negedge clk); tmr_we = 0;
        chk(tmr_count == 8'h10, "R5 load", tmr_count, 8'h10);
        idle(6);
        chk(tmr_count == 8'h10, "R5 two events dropped", tmr_count, 8'h10);
        idle(7);
        chk(tmr_count == 8'h11 || tmr_count == 8'h12, "R5 counting resumes", tmr_count, 8'h11);

        // R6 overflow flag
        wr_irq(8'h20);
        wr_tmr(8'hFE);
        idle(30);
        chk(irq_rdata[2] == 1'b1, "R6 flag set on wrap", irq_rdata[2], 1);
        chk(tmr_irq == 1'b1, "R6 irq asserted", tmr_irq, 1);
        idle(20);
        chk(irq_rdata[2] == 1'b1, "R6 flag sticky", irq_rdata[2], 1);
        wr_irq(8'h20);
        chk(irq_rdata == 8'h20 && !tmr_irq, "R6 flag cleared", irq_rdata, 8'h20);

        // R4 external pin, rising then falling
        wr_opt(8'h28);
        idle(8); c0 = tmr_count;
        pin_pulses(5, 3, 3); idle(8);
        chk(int'(tmr_count) == (c0 + 5) % 256, "R4 rising edges", tmr_count, (c0 + 5) % 256);
        wr_opt(8'h38);
        idle(8); c0 = tmr_count;
        pin_pulses(6, 2, 2); idle(8);
        chk(int'(tmr_count) == (c0 + 6) % 256, "R4 falling edges min width", tmr_count, (c0 + 6) % 256);

        // R8 periodic clears keep watchdog quiet and clear the scaler
        wr_opt(8'h08);
        np = 0;
        for (int i = 0; i < 8; i++) begin clr_wdt(); pulses_in(100, g); np += g; end
        chk(np == 0, "R8 cleared watchdog silent", np, 0);
        wr_opt(8'h09);
        clr_wdt(); idle(3 * PERIOD / 2);
        clr_wdt();
        pulses_in(2 * PERIOD - 16, g);
        chk(g == 0, "R8 scaler cleared by clear", g, 0);
        pulses_in(40, g);
        chk(g == 1, "R8 timeout after full interval", g, 1);

        // R9 assignment switch clears scaler
        wr_opt(8'h0B);
        clr_wdt(); idle(7 * PERIOD + PERIOD / 2);
        @(negedge clk); opt_we = 1; opt_wdata = 8'h03;
        @(negedge clk); opt_wdata = 8'h0B;
        @(negedge clk); opt_we = 0;
        pulses_in(7 * PERIOD, g);
        chk(g == 0, "R9 no spurious timeout after switch", g, 0);
        pulses_in(PERIOD, g);
        chk(g == 1, "R9 timeout after full ratio", g, 1);

        idle(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule